// File: doc/BRIEF.md
# Float Compare to Boolean Register

This unit compares two single-precision floating-point operands and writes the one-bit outcome into a selected bit of a sixteen-bit boolean predicate register. The other bits of that register keep their values. A three-bit operation code picks the relation. One code tests only for unordered operands, meaning that at least one operand is a NaN. The other six codes form three pairs: equal, less-than and less-or-equal, each in an ordered form and an unordered form. The ordered form is false when the operands are unordered. The unordered form is true when they are.

A processor pipeline presents the operands, the code and a four-bit destination index together with a valid strobe. The predicate register updates on that clock edge. Later conditional operations can read the predicate register from the output port.

All comparisons are quiet. A quiet NaN operand raises nothing. A signalling NaN operand sets a sticky invalid flag, which stays set until reset. Code 0 is reserved. It produces a one-cycle reserved indication and changes no state.

Top module: `fcmp_bool_unit`

## Requirements
- R1: While reset is asserted and after it is released, `breg_o` is all zeros and `invalid_o` and `reserved_o` are 0.
- R2: Code 1 (unordered) yields 1 exactly when either operand is a NaN. A NaN has an exponent of all ones and a nonzero fraction.
- R3: Code 2 yields 1 only for equal, non-NaN operands. Code 3 yields 1 for equal operands or for unordered operands.
- R4: Code 4 yields 1 only when a is less than b and neither operand is a NaN. Code 5 yields 1 when a is less than b or when the operands are unordered.
- R5: Code 6 yields 1 for less-or-equal with no NaN operand. Code 7 yields 1 exactly when a is not greater than b, which includes the unordered case.
- R6: +0 and -0 compare equal. Non-NaN values are ordered by sign and magnitude, so among negative values the one with the larger magnitude is smaller. Infinities order at the ends of the range.
- R7: A valid operation with a nonzero code writes its result into bit `dst_i` of `breg_o`, visible one clock after the valid edge. A result of 1 sets the bit and a result of 0 clears it. Every other bit keeps its value.
- R8: While `valid_i` is 0, `breg_o`, `invalid_o` and `reserved_o` do not change, whatever the other inputs hold (`reserved_o` stays 0).
- R9: A quiet NaN operand (fraction MSB 1) leaves `invalid_o` unchanged. A signalling NaN operand (fraction MSB 0) in a valid nonzero-code operation sets `invalid_o`, and `invalid_o` stays 1 until reset.
- R10: A valid operation with code 0 drives `reserved_o` to 1 for exactly the following cycle. It leaves `breg_o` and `invalid_o` unchanged, even when its operands are signalling NaNs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Relation code (0 reserved, 1 to 7 as in R2 to R5) |
| dst_i | input | 4 | Index of the predicate bit to write |
| a_i | input | 32 | First float operand |
| b_i | input | 32 | Second float operand |
| breg_o | output | 16 | Boolean predicate register |
| invalid_o | output | 1 | Sticky invalid flag for signalling NaNs |
| reserved_o | output | 1 | One-cycle indication of a reserved code |

## Verification
The bench builds the block with its default parameters: 16 predicate bits, an 8-bit exponent and a 23-bit fraction. With these values the operands are ordinary single-precision encodings. Zeros of both signs, infinities, quiet NaNs and signalling NaNs can then be written directly as hex constants, and destination indices 0 and 15 reach both ends of the predicate register. An independent model in the bench maps each operand to an unsigned ordering key and derives the expected predicate register and flags from that key.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [2:0] {
        OP_RSV = 3'd0,
        OP_UN  = 3'd1,
        OP_OEQ = 3'd2,
        OP_UEQ = 3'd3,
        OP_OLT = 3'd4,
        OP_ULT = 3'd5,
        OP_OLE = 3'd6,
        OP_ULE = 3'd7
    } cmp_op_e;

    // operand classification
    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
    } fclass_t;

    // relation between two operands; eq and lt are valid only when un is 0
    typedef struct packed {
        logic un;
        logic eq;
        logic lt;
    } frel_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val_i,
    output fclass_t              cls_o
);
    localparam int FW = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] exp_w;
    logic [MAN_W-1:0] frac_w;

    always_comb begin
        exp_w       = val_i[FW-2:MAN_W];
        frac_w      = val_i[MAN_W-1:0];
        cls_o.nan   = (&exp_w) && (|frac_w);
        cls_o.snan  = (&exp_w) && (|frac_w) && !frac_w[MAN_W-1];
        cls_o.zero  = (val_i[FW-2:0] == '0);
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] b_i,
    input  fclass_t              cls_a_i,
    input  fclass_t              cls_b_i,
    output frel_t                rel_o
);
    localparam int FW = EXP_W + MAN_W + 1;

    logic [FW-2:0] mag_a, mag_b;
    logic          sgn_a, sgn_b;
    logic          both_zero, eq_raw, lt_raw;

    always_comb begin
        mag_a     = a_i[FW-2:0];
        mag_b     = b_i[FW-2:0];
        sgn_a     = a_i[FW-1];
        sgn_b     = b_i[FW-1];
        both_zero = cls_a_i.zero && cls_b_i.zero;
        eq_raw    = both_zero || (a_i == b_i);
        lt_raw    = 1'b0;
        if (!both_zero) begin
            unique case ({sgn_a, sgn_b})
                2'b10:   lt_raw = 1'b1;
                2'b01:   lt_raw = 1'b0;
                2'b00:   lt_raw = (mag_a < mag_b);
                default: lt_raw = (mag_a > mag_b);
            endcase
        end
        rel_o.un = cls_a_i.nan || cls_b_i.nan;
        rel_o.eq = eq_raw && !rel_o.un;
        rel_o.lt = lt_raw && !rel_o.un;
    end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
    import fcmp_pkg::*;
(
    input  logic [2:0] op_i,
    input  frel_t      rel_i,
    output logic       pred_o,
    output logic       legal_o
);
    always_comb begin
        legal_o = 1'b1;
        unique case (cmp_op_e'(op_i))
            OP_UN:   pred_o = rel_i.un;
            OP_OEQ:  pred_o = rel_i.eq;
            OP_UEQ:  pred_o = rel_i.eq || rel_i.un;
            OP_OLT:  pred_o = rel_i.lt;
            OP_ULT:  pred_o = rel_i.lt || rel_i.un;
            OP_OLE:  pred_o = rel_i.lt || rel_i.eq;
            OP_ULE:  pred_o = rel_i.lt || rel_i.eq || rel_i.un;
            default: begin
                pred_o  = 1'b0;
                legal_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fcmp_bool_unit.sv
module fcmp_bool_unit
    import fcmp_pkg::*;
#(
    parameter int NBOOL = 16,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int FW    = EXP_W + MAN_W + 1,
    localparam int IDX_W = $clog2(NBOOL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [2:0]       op_i,
    input  logic [IDX_W-1:0] dst_i,
    input  logic [FW-1:0]    a_i,
    input  logic [FW-1:0]    b_i,
    output logic [NBOOL-1:0] breg_o,
    output logic             invalid_o,
    output logic             reserved_o
);
    typedef struct packed {
        logic [NBOOL-1:0] breg;
        logic             inv;
        logic             rsv;
    } state_t;

    state_t state_d, state_q;

    logic [FW-1:0] opnd [2];
    fclass_t       cls  [2];
    frel_t         rel;
    logic          pred, legal;

    assign opnd[0] = a_i;
    assign opnd[1] = b_i;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val_i (opnd[g]),
            .cls_o (cls[g])
        );
    end

    fcmp_relate #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
        .a_i     (a_i),
        .b_i     (b_i),
        .cls_a_i (cls[0]),
        .cls_b_i (cls[1]),
        .rel_o   (rel)
    );

    fcmp_predicate u_pred (
        .op_i    (op_i),
        .rel_i   (rel),
        .pred_o  (pred),
        .legal_o (legal)
    );

    always_comb begin
        state_d     = state_q;
        state_d.rsv = 1'b0;
        if (valid_i) begin
            if (!legal) begin
                state_d.rsv = 1'b1;
            end else begin
                for (int i = 0; i < NBOOL; i++) begin
                    if (dst_i == IDX_W'(i)) state_d.breg[i] = pred;
                end
                if (cls[0].snan || cls[1].snan) state_d.inv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign breg_o     = state_q.breg;
    assign invalid_o  = state_q.inv;
    assign reserved_o = state_q.rsv;
endmodule

// File: rtl/fcmp_bool_unit_chk.sv
module fcmp_bool_unit_chk #(
    parameter int NBOOL = 16,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int FW    = EXP_W + MAN_W + 1,
    localparam int IDX_W = $clog2(NBOOL)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [2:0]       op_i,
    input logic [IDX_W-1:0] dst_i,
    input logic [FW-1:0]    a_i,
    input logic [FW-1:0]    b_i,
    input logic [NBOOL-1:0] breg_o,
    input logic             invalid_o,
    input logic             reserved_o
);
    logic sig_nan_in;
    assign sig_nan_in =
        ((&a_i[FW-2:MAN_W]) && (|a_i[MAN_W-2:0]) && !a_i[MAN_W-1]) ||
        ((&b_i[FW-2:MAN_W]) && (|b_i[MAN_W-2:0]) && !b_i[MAN_W-1]);

    // R7
    other_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i != 3'd0) |=>
        (((breg_o ^ $past(breg_o)) & ~(NBOOL'(1) << $past(dst_i))) == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(breg_o) && $stable(invalid_o) && !reserved_o));

    // R10
    reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd0) |=> (reserved_o && $stable(breg_o) && $stable(invalid_o)));

    // R10
    reserved_only_after_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && op_i == 3'd0) |=> !reserved_o);

    // R9
    invalid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |=> invalid_o);

    // R9
    quiet_no_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_nan_in |=> $stable(invalid_o));

    // R9
    signal_sets_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i != 3'd0 && sig_nan_in) |=> invalid_o);
endmodule

bind fcmp_bool_unit fcmp_bool_unit_chk #(
    .NBOOL(NBOOL), .EXP_W(EXP_W), .MAN_W(MAN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .op_i       (op_i),
    .dst_i      (dst_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .breg_o     (breg_o),
    .invalid_o  (invalid_o),
    .reserved_o (reserved_o)
);

// File: tb/fcmp_bool_unit_tb.sv
module fcmp_bool_unit_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] P1   = 32'h3F80_0000;
    localparam logic [31:0] P2   = 32'h4000_0000;
    localparam logic [31:0] N1   = 32'hBF80_0000;
    localparam logic [31:0] N2   = 32'hC000_0000;
    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;
    localparam logic [31:0] SNAN = 32'h7F80_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [3:0]  dst_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [15:0] breg_o;
    logic        invalid_o;
    logic        reserved_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic [15:0] breg;
        logic        inv;
        logic        rsv;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [15:0] m_breg = '0;
    logic        m_inv  = 1'b0;

    fcmp_bool_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .dst_i(dst_i), .a_i(a_i), .b_i(b_i), .breg_o(breg_o),
        .invalid_o(invalid_o), .reserved_o(reserved_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic is_nan(logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic logic [31:0] okey(logic [31:0] v);
        if (v[30:0] == 0) return 32'h8000_0000;
        return v[31] ? ~v : (v | 32'h8000_0000);
    endfunction

    function automatic logic model_pred(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic un, lt, eq;
        un = is_nan(a) || is_nan(b);
        lt = !un && (okey(a) < okey(b));
        eq = !un && (okey(a) == okey(b));
        case (op)
            3'd1: return un;
            3'd2: return eq;
            3'd3: return eq || un;
            3'd4: return lt;
            3'd5: return lt || un;
            3'd6: return lt || eq;
            default: return !(!un && !lt && !eq);
        endcase
    endfunction

    task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got breg=%h inv=%b rsv=%b, expected breg=%h inv=%b rsv=%b",
                     tag, act[17:2], act[1], act[0], exp[17:2], exp[1], exp[0]);
        end
    endtask

    // driver: issue one operation and push the expected outcome
    task automatic drive(string tag, logic [2:0] op, logic [3:0] dst,
                         logic [31:0] a, logic [31:0] b);
        exp_t e;
        @(negedge clk);
        valid_i = 1'b1; op_i = op; dst_i = dst; a_i = a; b_i = b;
        e.rsv = (op == 3'd0);
        if (op != 3'd0) begin
            m_breg[dst] = model_pred(op, a, b);
            if ((is_nan(a) && !a[22]) || (is_nan(b) && !b[22])) m_inv = 1'b1;
        end
        e.breg = m_breg;
        e.inv  = m_inv;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        valid_i = 1'b0; op_i = 3'd7; dst_i = 4'd3; a_i = SNAN; b_i = P1;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare outputs one cycle after each valid edge
    initial begin
        forever begin
            logic fired;
            @(posedge clk);
            fired = valid_i && rst_n;
            @(negedge clk);
            if (fired && exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {breg_o, invalid_o, reserved_o}, {e.breg, e.inv, e.rsv});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {breg_o, invalid_o, reserved_o}, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {breg_o, invalid_o, reserved_o}, 18'd0);

        drive("R2 un ordered",   3'd1, 4'd0,  P1, P2);
        drive("R2 un qnan a",    3'd1, 4'd1,  QNAN, P2);
        drive("R2 un qnan b",    3'd1, 4'd2,  N1, QNAN);
        drive("R3 oeq equal",    3'd2, 4'd3,  P2, P2);
        drive("R3 oeq nan",      3'd2, 4'd4,  QNAN, QNAN);
        drive("R3 ueq nan",      3'd3, 4'd5,  QNAN, P1);
        drive("R3 ueq diff",     3'd3, 4'd6,  P1, P2);
        drive("R4 olt true",     3'd4, 4'd7,  P1, P2);
        drive("R4 olt nan",      3'd4, 4'd8,  P1, QNAN);
        drive("R4 ult nan",      3'd5, 4'd9,  QNAN, P1);
        drive("R4 ult false",    3'd5, 4'd10, P2, P1);
        drive("R5 ole equal",    3'd6, 4'd11, N2, N2);
        drive("R5 ole nan",      3'd6, 4'd12, QNAN, N2);
        drive("R5 ule nan",      3'd7, 4'd13, P1, QNAN);
        drive("R5 ule greater",  3'd7, 4'd13, P2, P1);
        drive("R6 zeros eq",     3'd2, 4'd14, PZ, NZ);
        drive("R6 negzero lt",   3'd4, 4'd15, NZ, PZ);
        drive("R6 neg mag",      3'd4, 4'd15, N2, N1);
        drive("R6 neg vs pos",   3'd4, 4'd0,  N1, P1);
        drive("R6 ninf lt",      3'd4, 4'd1,  NINF, N2);
        drive("R6 pinf gt",      3'd6, 4'd2,  PINF, P2);
        drive("R7 clear bit 3",  3'd2, 4'd3,  P1, P2);
        drive("R7 set bit 15",   3'd7, 4'd15, PZ, NZ);
        drive("R9 quiet nan",    3'd1, 4'd4,  QNAN, QNAN);
        drive("R10 reserved",    3'd0, 4'd5,  SNAN, SNAN);
        drive("R10 after rsv",   3'd1, 4'd6,  P1, P1);
        idle(4);
        check("R8 idle hold", {breg_o, invalid_o, reserved_o}, {m_breg, m_inv, 1'b0});
        drive("R9 snan sets",    3'd2, 4'd7,  SNAN, P1);
        drive("R9 sticky",       3'd4, 4'd8,  P1, P2);
        idle(3);
        check("R9 sticky idle", {breg_o, invalid_o, reserved_o}, {m_breg, 1'b1, 1'b0});

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule